// File: doc/BRIEF.md
# Power-Register Command Executor

This block is the controller-side engine that carries out power-control register commands posted to a mailbox. A doorbell pulse hands it a command made of three fields and a 16-byte write buffer. The fields are the message type, the command id and the size. The block latches everything on the doorbell and validates the command. It then drives a byte-wide register-file port with 16-bit addresses, one access per cycle. Read results go into a 16-byte read buffer.

Three operations are supported. A list read fetches up to five registers. A list write stores up to five registers. A masked read-modify-write updates selected bits of one register. Each command ends with a single-cycle completion strobe, which carries an error flag and an error code. A command that fails validation performs no register access.

Top module: `pwr_cmd_exec`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `reg_rd_o` and `reg_wr_o` are 0, `err_code_o` is 0 and the read buffer is all zero.
- R2: A message type other than 0xFF completes with `err_o`=1, error code 1 and no register access.
- R3: Command id 0 is write, 1 is read and 2 is read-modify-write. Any other id completes with error code 2 and no register access.
- R4: A read of N registers requires size 2N. Address i is taken from buffer bytes 2i (low) and 2i+1 (high). One read strobe is issued per cycle in list order. Result i is placed in read-buffer byte i, and all other read-buffer bytes read 0.
- R5: A write of N registers requires size 3N. The data byte for address i sits at buffer byte 2N+i. One write strobe is issued per cycle in list order.
- R6: Read-modify-write requires size 4. The address is in bytes 0 and 1, the value in byte 2 and the mask in byte 3. The block reads the register and then writes back (old AND NOT mask) OR (value AND mask) to the same address.
- R7: A register count of 0 or above 5 completes with error code 3 and no register access.
- R8: A size that does not fit the command id completes with error code 4 and no register access. This covers an odd size for a read, a size that is not a multiple of 3 for a write, and a size other than 4 for read-modify-write.
- R9: `done_o` is a one-cycle pulse. Counted from the clock edge that accepts the doorbell, it appears after N+2 edges for a read or write, after 5 edges for read-modify-write and after 2 edges for a rejected command. `err_o` and `err_code_o` are valid with it, and the code is 0 on success.
- R10: `busy_o` is high from the edge after acceptance until the completion edge. A doorbell seen while `busy_o` is high is ignored.
- R11: Read and write strobes are never active in the same cycle, and no strobe appears while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| doorbell_i | input | 1 | Command posted; fields and buffer are valid |
| msg_type_i | input | 8 | Message type field |
| cmd_id_i | input | 4 | Command id field |
| size_i | input | 8 | Payload byte count field |
| wbuf_i | input | 128 | Write buffer; byte k at bits 8k+7:8k |
| reg_addr_o | output | 16 | Register-file address |
| reg_rd_o | output | 1 | Read strobe; data is expected on `reg_rdata_i` in the next cycle |
| reg_wr_o | output | 1 | Write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data, one cycle after the strobe |
| rbuf_o | output | 128 | Read buffer; byte k at bits 8k+7:8k |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion strobe |
| err_o | output | 1 | Command rejected |
| err_code_o | output | 8 | 0 ok, 1 type, 2 id, 3 count, 4 size |

## Verification
Reads are run with one address and with five. Together they show that the list is walked in order, that the run stops at the count and that unused read-buffer bytes are cleared between commands. Writes of one and five registers are read back. This exposes a data-byte offset taken from the wrong base. Read-modify-write is run with a mixed mask, an empty mask and a full mask, which tells the polarity of the mask apart from the direction of the merge. Rejected commands cover each error cause at both edges of the count range. A doorbell pulsed during a long write shows whether a busy block restarts or re-latches.

// File: rtl/pwr_cmd_pkg.sv
package pwr_cmd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_RD  = 2'd1,
    OP_RMW = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_ACCESS,
    ST_RMW_WAIT,
    ST_RMW_WR,
    ST_FINISH
  } state_e;

  localparam logic [7:0] ERR_NONE  = 8'd0;
  localparam logic [7:0] ERR_TYPE  = 8'd1;
  localparam logic [7:0] ERR_ID    = 8'd2;
  localparam logic [7:0] ERR_COUNT = 8'd3;
  localparam logic [7:0] ERR_SIZE  = 8'd4;
endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_cmd_pkg::*;
#(
  parameter int unsigned MAX_REGS  = 5,
  parameter logic [7:0]  MSG_PCTRL = 8'hFF,
  localparam int unsigned CNT_W    = $clog2(MAX_REGS + 1)
) (
  input  logic [7:0]       msg_type_i,
  input  logic [3:0]       cmd_id_i,
  input  logic [7:0]       size_i,
  output logic             ok_o,
  output op_e              op_o,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       code_o
);
  logic [7:0] cnt;

  always_comb begin
    code_o = ERR_NONE;
    op_o   = OP_RD;
    cnt    = '0;
    if (msg_type_i != MSG_PCTRL) begin
      code_o = ERR_TYPE;
    end else begin
      unique case (cmd_id_i)
        4'd0: begin
          op_o = OP_WR;
          if ((size_i % 8'd3) != 8'd0) code_o = ERR_SIZE;
          else                         cnt    = size_i / 8'd3;
        end
        4'd1: begin
          op_o = OP_RD;
          if (size_i[0]) code_o = ERR_SIZE;
          else           cnt    = {1'b0, size_i[7:1]};
        end
        4'd2: begin
          op_o = OP_RMW;
          if (size_i != 8'd4) code_o = ERR_SIZE;
          else                cnt    = 8'd1;
        end
        default: code_o = ERR_ID;
      endcase
    end
    if (code_o == ERR_NONE && (cnt == 8'd0 || cnt > 8'(MAX_REGS)))
      code_o = ERR_COUNT;
    ok_o    = (code_o == ERR_NONE);
    count_o = cnt[CNT_W-1:0];
  end
endmodule

// File: rtl/pwr_cmd_seq.sv
module pwr_cmd_seq
  import pwr_cmd_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned MAX_REGS  = 5,
  localparam int unsigned CNT_W    = $clog2(MAX_REGS + 1),
  localparam int unsigned BI_W     = $clog2(BUF_BYTES),
  localparam int unsigned BUF_W    = BUF_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              doorbell_i,
  input  logic              dec_ok_i,
  input  op_e               dec_op_i,
  input  logic [CNT_W-1:0]  dec_count_i,
  input  logic [7:0]        dec_code_i,
  input  logic [BUF_W-1:0]  wbuf_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        err_code_o,
  output logic [15:0]       reg_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [7:0]        reg_wdata_o,
  input  logic [7:0]        reg_rdata_i,
  output logic              cap_en_o,
  output logic [BI_W-1:0]   cap_idx_o,
  output logic [7:0]        cap_data_o
);
  state_e           state_q, state_d;
  op_e              op_q;
  logic [CNT_W-1:0] idx_q, cnt_q, rd_idx_q;
  logic             rd_pend_q, err_q, done_q;
  logic [7:0]       code_q, old_q;
  logic [BI_W-1:0]  lo_ix, hi_ix, dat_ix;
  logic             last_idx;

  function automatic logic [7:0] wb_byte(input logic [BI_W-1:0] ix);
    return wbuf_i[ix*BYTE_W +: BYTE_W];
  endfunction

  assign lo_ix    = BI_W'(2 * int'(idx_q));
  assign hi_ix    = BI_W'(2 * int'(idx_q) + 1);
  assign dat_ix   = BI_W'(2 * int'(cnt_q) + int'(idx_q));
  assign last_idx = (CNT_W'(idx_q + 1'b1) == cnt_q);
  assign accept_o = doorbell_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (doorbell_i) state_d = ST_DECODE;
      ST_DECODE:   state_d = dec_ok_i ? ST_ACCESS : ST_FINISH;
      ST_ACCESS: begin
        if (op_q == OP_RMW) state_d = ST_RMW_WAIT;
        else if (last_idx)  state_d = ST_FINISH;
      end
      ST_RMW_WAIT: state_d = ST_RMW_WR;
      ST_RMW_WR:   state_d = ST_FINISH;
      ST_FINISH:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    reg_rd_o    = 1'b0;
    reg_wr_o    = 1'b0;
    reg_addr_o  = '0;
    reg_wdata_o = '0;
    if (state_q == ST_ACCESS) begin
      reg_addr_o = {wb_byte(hi_ix), wb_byte(lo_ix)};
      if (op_q == OP_WR) begin
        reg_wr_o    = 1'b1;
        reg_wdata_o = wb_byte(dat_ix);
      end else begin
        reg_rd_o = 1'b1;
      end
    end else if (state_q == ST_RMW_WR) begin
      reg_addr_o  = {wb_byte(BI_W'(1)), wb_byte(BI_W'(0))};
      reg_wr_o    = 1'b1;
      // mask bit 1 selects the new value
      reg_wdata_o = (old_q & ~wb_byte(BI_W'(3))) | (wb_byte(BI_W'(2)) & wb_byte(BI_W'(3)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_RD;
      idx_q     <= '0;
      cnt_q     <= '0;
      rd_idx_q  <= '0;
      rd_pend_q <= 1'b0;
      err_q     <= 1'b0;
      code_q    <= ERR_NONE;
      done_q    <= 1'b0;
      old_q     <= '0;
    end else begin
      state_q   <= state_d;
      done_q    <= (state_q == ST_FINISH);
      rd_pend_q <= reg_rd_o;
      rd_idx_q  <= idx_q;
      if (rd_pend_q && op_q == OP_RMW) old_q <= reg_rdata_i;
      if (state_q == ST_DECODE) begin
        op_q   <= dec_op_i;
        cnt_q  <= dec_count_i;
        idx_q  <= '0;
        err_q  <= !dec_ok_i;
        code_q <= dec_code_i;
      end else if (state_q == ST_ACCESS && op_q != OP_RMW && !last_idx) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
  assign cap_en_o   = rd_pend_q && (op_q == OP_RD);
  assign cap_idx_o  = BI_W'(rd_idx_q);
  assign cap_data_o = reg_rdata_i;
endmodule

// File: rtl/pwr_cmd_rbuf.sv
module pwr_cmd_rbuf
  import pwr_cmd_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 16,
  localparam int unsigned BI_W     = $clog2(BUF_BYTES),
  localparam int unsigned BUF_W    = BUF_BYTES * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             cap_en_i,
  input  logic [BI_W-1:0]  cap_idx_i,
  input  logic [7:0]       cap_data_i,
  output logic [BUF_W-1:0] rbuf_o
);
  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  byte_q <= '0;
      else if (clear_i)                             byte_q <= '0;
      else if (cap_en_i && cap_idx_i == BI_W'(g))   byte_q <= cap_data_i;
    end
    assign rbuf_o[g*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/pwr_cmd_exec.sv
module pwr_cmd_exec
  import pwr_cmd_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned MAX_REGS  = 5,
  parameter logic [7:0]  MSG_PCTRL = 8'hFF,
  localparam int unsigned CNT_W    = $clog2(MAX_REGS + 1),
  localparam int unsigned BI_W     = $clog2(BUF_BYTES),
  localparam int unsigned BUF_W    = BUF_BYTES * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             doorbell_i,
  input  logic [7:0]       msg_type_i,
  input  logic [3:0]       cmd_id_i,
  input  logic [7:0]       size_i,
  input  logic [BUF_W-1:0] wbuf_i,
  output logic [15:0]      reg_addr_o,
  output logic             reg_rd_o,
  output logic             reg_wr_o,
  output logic [7:0]       reg_wdata_o,
  input  logic [7:0]       reg_rdata_i,
  output logic [BUF_W-1:0] rbuf_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       err_code_o
);
  logic [7:0]       type_q, size_q;
  logic [3:0]       id_q;
  logic [BUF_W-1:0] wbuf_q;
  logic             accept, dec_ok, cap_en;
  op_e              dec_op;
  logic [CNT_W-1:0] dec_count;
  logic [7:0]       dec_code, cap_data;
  logic [BI_W-1:0]  cap_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      id_q   <= '0;
      size_q <= '0;
      wbuf_q <= '0;
    end else if (accept) begin
      type_q <= msg_type_i;
      id_q   <= cmd_id_i;
      size_q <= size_i;
      wbuf_q <= wbuf_i;
    end
  end

  pwr_cmd_decode #(.MAX_REGS(MAX_REGS), .MSG_PCTRL(MSG_PCTRL)) u_dec (
    .msg_type_i (type_q),
    .cmd_id_i   (id_q),
    .size_i     (size_q),
    .ok_o       (dec_ok),
    .op_o       (dec_op),
    .count_o    (dec_count),
    .code_o     (dec_code)
  );

  pwr_cmd_seq #(.BUF_BYTES(BUF_BYTES), .MAX_REGS(MAX_REGS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .doorbell_i  (doorbell_i),
    .dec_ok_i    (dec_ok),
    .dec_op_i    (dec_op),
    .dec_count_i (dec_count),
    .dec_code_i  (dec_code),
    .wbuf_i      (wbuf_q),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o),
    .reg_addr_o  (reg_addr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_wr_o    (reg_wr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rdata_i (reg_rdata_i),
    .cap_en_o    (cap_en),
    .cap_idx_o   (cap_idx),
    .cap_data_o  (cap_data)
  );

  pwr_cmd_rbuf #(.BUF_BYTES(BUF_BYTES)) u_rbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .cap_en_i   (cap_en),
    .cap_idx_i  (cap_idx),
    .cap_data_i (cap_data),
    .rbuf_o     (rbuf_o)
  );
endmodule

// File: rtl/pwr_cmd_exec_chk.sv
module pwr_cmd_exec_chk #(
  parameter int unsigned BUF_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             doorbell_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [7:0]       err_code_o,
  input logic             reg_rd_o,
  input logic             reg_wr_o,
  input logic [BUF_W-1:0] rbuf_o
);
  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o));

  p_strobe_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o || reg_wr_o) |-> busy_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_follows_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o);

  p_code_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o == (err_code_o != 8'd0)));

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && doorbell_i) |=> busy_o);

  p_rbuf_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !doorbell_i) |=> $stable(rbuf_o));
endmodule

bind pwr_cmd_exec pwr_cmd_exec_chk #(.BUF_W(BUF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .doorbell_i (doorbell_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .err_code_o (err_code_o),
  .reg_rd_o   (reg_rd_o),
  .reg_wr_o   (reg_wr_o),
  .rbuf_o     (rbuf_o)
);

// File: tb/pwr_cmd_exec_test.sv
module pwr_cmd_exec_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         doorbell_i = 1'b0;
  logic [7:0]   msg_type_i = '0;
  logic [3:0]   cmd_id_i = '0;
  logic [7:0]   size_i = '0;
  logic [127:0] wbuf_i = '0;
  logic [15:0]  reg_addr_o;
  logic         reg_rd_o, reg_wr_o;
  logic [7:0]   reg_wdata_o;
  logic [7:0]   reg_rdata_i = '0;
  logic [127:0] rbuf_o;
  logic         busy_o, done_o, err_o;
  logic [7:0]   err_code_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  logic [7:0] wb [16];

  always #4 clk_i = ~clk_i;

  pwr_cmd_exec uut (
    .clk_i, .rst_ni, .doorbell_i, .msg_type_i, .cmd_id_i, .size_i, .wbuf_i,
    .reg_addr_o, .reg_rd_o, .reg_wr_o, .reg_wdata_o, .reg_rdata_i,
    .rbuf_o, .busy_o, .done_o, .err_o, .err_code_o
  );

  function automatic logic [7:0] init_val(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] dut_mem_rd(int a);
    return mem.exists(a) ? mem[a] : init_val(a);
  endfunction

  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
  endfunction

  // register file seen by the design
  always @(posedge clk_i) begin
    if (reg_rd_o) reg_rdata_i <= dut_mem_rd(int'(reg_addr_o));
    if (reg_wr_o) mem[int'(reg_addr_o)] = reg_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_wb();
    for (int i = 0; i < 16; i++) wb[i] = 8'h00;
  endtask

  task automatic put_addr(input int i, input logic [15:0] a);
    wb[2*i]   = a[7:0];
    wb[2*i+1] = a[15:8];
  endtask

  task automatic run_cmd(input logic [7:0] t, input logic [3:0] id, input logic [7:0] sz,
                         input bit poke, input string req);
    int code, n, lat;
    bit e_rd [16];
    bit e_wr [16];
    int e_addr [16];
    int e_dat [16];
    logic [7:0] e_rbuf [16];
    bit cyc_ok;
    for (int k = 0; k < 16; k++) begin
      e_rd[k] = 0; e_wr[k] = 0; e_addr[k] = 0; e_dat[k] = 0; e_rbuf[k] = 0;
    end
    code = 0; n = 0;
    if (t != 8'hFF) code = 1;
    else if (id == 4'd1) begin if (sz % 2 != 0) code = 4; else n = sz / 2; end
    else if (id == 4'd0) begin if (sz % 3 != 0) code = 4; else n = sz / 3; end
    else if (id == 4'd2) begin if (sz != 4) code = 4; else n = 1; end
    else code = 2;
    if (code == 0 && (n < 1 || n > 5)) code = 3;
    lat = (code != 0) ? 2 : (id == 4'd2 ? 5 : n + 2);
    if (code == 0) begin
      if (id == 4'd1) begin
        for (int i = 0; i < n; i++) begin
          e_rd[i+1] = 1; e_addr[i+1] = {wb[2*i+1], wb[2*i]};
          e_rbuf[i] = ref_rd(e_addr[i+1]);
        end
      end else if (id == 4'd0) begin
        for (int i = 0; i < n; i++) begin
          e_wr[i+1] = 1; e_addr[i+1] = {wb[2*i+1], wb[2*i]}; e_dat[i+1] = wb[2*n+i];
          ref_mem[e_addr[i+1]] = wb[2*n+i];
        end
      end else begin
        logic [7:0] old_v, new_v;
        e_addr[1] = {wb[1], wb[0]}; e_addr[3] = e_addr[1];
        old_v = ref_rd(e_addr[1]);
        new_v = (old_v & ~wb[3]) | (wb[2] & wb[3]);
        e_rd[1] = 1; e_wr[3] = 1; e_dat[3] = new_v;
        ref_mem[e_addr[1]] = new_v;
      end
    end
    @(negedge clk_i);
    msg_type_i = t; cmd_id_i = id; size_i = sz;
    for (int i = 0; i < 16; i++) wbuf_i[i*8 +: 8] = wb[i];
    doorbell_i = 1'b1;
    @(negedge clk_i);
    doorbell_i = 1'b0;
    wbuf_i = '1; msg_type_i = 8'h00;  // fields must have been latched
    chk(busy_o && !reg_rd_o && !reg_wr_o && !done_o, "R10", "busy after accept",
        {busy_o, reg_rd_o, reg_wr_o, done_o}, 8);
    for (int k = 1; k <= lat + 1; k++) begin
      @(negedge clk_i);
      cyc_ok = (reg_rd_o == e_rd[k]) && (reg_wr_o == e_wr[k]) && (done_o == (k == lat));
      if (e_rd[k] || e_wr[k]) cyc_ok = cyc_ok && (int'(reg_addr_o) == e_addr[k]);
      if (e_wr[k]) cyc_ok = cyc_ok && (int'(reg_wdata_o) == e_dat[k]);
      chk(cyc_ok, req, $sformatf("cycle %0d rd/wr/done/addr/wdata", k),
          {reg_rd_o, reg_wr_o, done_o, reg_addr_o, reg_wdata_o},
          {e_rd[k], e_wr[k], (k == lat), e_addr[k][15:0], e_dat[k][7:0]});
      if (k == lat) begin
        chk(err_o == (code != 0) && int'(err_code_o) == code, "R9", "err flag/code",
            {err_o, err_code_o}, code);
        for (int i = 0; i < 16; i++)
          chk(rbuf_o[i*8 +: 8] == e_rbuf[i], "R4", $sformatf("rbuf byte %0d", i),
              rbuf_o[i*8 +: 8], e_rbuf[i]);
        chk(!busy_o, "R10", "idle at completion", busy_o, 0);
      end
      if (poke && k == 1) begin
        msg_type_i = 8'hFF; cmd_id_i = 4'd0; size_i = 8'd3; wbuf_i = '0;
        doorbell_i = 1'b1;
      end
      if (poke && k == 2) doorbell_i = 1'b0;
    end
    chk(!busy_o && !reg_rd_o && !reg_wr_o, "R10", "no activity after completion",
        {busy_o, reg_rd_o, reg_wr_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && err_code_o == 0 && rbuf_o == '0
        && !reg_rd_o && !reg_wr_o, "R1", "reset state",
        {busy_o, done_o, err_o, reg_rd_o, reg_wr_o, err_code_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 single read
    clear_wb(); put_addr(0, 16'h1234);
    run_cmd(8'hFF, 4'd1, 8'd2, 0, "R4");
    // R4 five reads, boundary count
    clear_wb();
    put_addr(0, 16'h0010); put_addr(1, 16'hBEEF); put_addr(2, 16'h0001);
    put_addr(3, 16'hFF00); put_addr(4, 16'h7777);
    run_cmd(8'hFF, 4'd1, 8'd10, 0, "R4");
    // R5 single write then read back
    clear_wb(); put_addr(0, 16'h1234); wb[2] = 8'h3C;
    run_cmd(8'hFF, 4'd0, 8'd3, 0, "R5");
    clear_wb(); put_addr(0, 16'h1234);
    run_cmd(8'hFF, 4'd1, 8'd2, 0, "R5");
    // R5 five writes with busy doorbell (R10), then read back
    clear_wb();
    put_addr(0, 16'h0100); put_addr(1, 16'h0201); put_addr(2, 16'h0302);
    put_addr(3, 16'h0403); put_addr(4, 16'h0504);
    wb[10] = 8'h11; wb[11] = 8'h22; wb[12] = 8'h33; wb[13] = 8'h44; wb[14] = 8'h55;
    run_cmd(8'hFF, 4'd0, 8'd15, 1, "R10");
    run_cmd(8'hFF, 4'd1, 8'd10, 0, "R5");
    // R6 masked update variants
    clear_wb(); put_addr(0, 16'h0201); wb[2] = 8'hA5; wb[3] = 8'hF0;
    run_cmd(8'hFF, 4'd2, 8'd4, 0, "R6");
    clear_wb(); put_addr(0, 16'h0201); wb[2] = 8'hFF; wb[3] = 8'h00;
    run_cmd(8'hFF, 4'd2, 8'd4, 0, "R6");
    clear_wb(); put_addr(0, 16'h4242); wb[2] = 8'h5A; wb[3] = 8'hFF;
    run_cmd(8'hFF, 4'd2, 8'd4, 0, "R6");
    clear_wb(); put_addr(0, 16'h0201); put_addr(1, 16'h4242);
    run_cmd(8'hFF, 4'd1, 8'd4, 0, "R6");
    // R2 bad type, R3 bad id
    clear_wb(); put_addr(0, 16'h1234);
    run_cmd(8'h7F, 4'd1, 8'd2, 0, "R2");
    run_cmd(8'hFF, 4'd3, 8'd2, 0, "R3");
    // R7 count out of range
    run_cmd(8'hFF, 4'd1, 8'd12, 0, "R7");
    run_cmd(8'hFF, 4'd0, 8'd18, 0, "R7");
    run_cmd(8'hFF, 4'd1, 8'd0, 0, "R7");
    // R8 size mismatch
    run_cmd(8'hFF, 4'd1, 8'd3, 0, "R8");
    run_cmd(8'hFF, 4'd0, 8'd4, 0, "R8");
    run_cmd(8'hFF, 4'd2, 8'd2, 0, "R8");
    // R11 rejected commands left the register file untouched
    clear_wb(); put_addr(0, 16'h1234);
    run_cmd(8'hFF, 4'd1, 8'd2, 0, "R11");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule